// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block turns a single processor-side bus request into the pin activity of one DRAM access. The request carries a word address, a read/write flag, upper and lower byte-lane enables, an area index and a column-strobe pin-select bit. The block first runs a precharge state, then a row state, then two column states. It drives one active-low row strobe per DRAM area and a 13-bit multiplexed row/column address. It also drives upper and lower column strobes on one of two pin pairs, plus a write enable and a data-bus output enable. A per-area wait-enable vector decides whether an external wait request may stretch the cycle between the two column states. When that is allowed, the wait states are added to the four basic states.

Between accesses the block also accepts a refresh request, which takes priority over a pending access. It then runs a fixed three-state column-before-row refresh with the refresh indicator low and returns a one-cycle done pulse. A request marked non-DRAM is not run here: the block hands it to the ordinary bus controller through a one-cycle go pulse. If that request is accepted on the first idle cycle after a DRAM access that used the write-strobe pins as column strobes, one idle state is inserted first.

Top module: `dram_cycle_seq`

## Requirements
- R1: A DRAM request accepted at a clock edge (ready high, no refresh request) is followed, from the next cycle on, by exactly Tp, Tr, Tc1, then zero or more wait states, then Tc2, then idle with ready high again.
- R2: Row strobe bit i (area index i, meaning DRAM area i+2) is low from Tr through Tc2, including wait states. All other row strobes stay high, and all row strobes are high in Tp and idle.
- R3: The address output carries the row, address bits 22..10, in Tp and Tr. In Tc1, wait states and Tc2 it carries the column, address bits 9..0 zero-extended to 13 bits. It is zero at all other times.
- R4: When the addressed area's wait-enable bit is 1 and wait request is high at the end of Tc1, wait states follow. They last until the first clock edge at which wait request is low, and then Tc2 follows.
- R5: When the addressed area's wait-enable bit is 0, Tc2 always follows Tc1 directly, whatever wait request does. The wait-enable bits of other areas have no effect.
- R6: Column strobes are low only in Tc2, upper for upper-lane enable and lower for lower-lane enable. With pin select 0 they appear on the port pair and the write-strobe pair stays high. With pin select 1 it is the other way round.
- R7: Write enable is low and data output enable is high from Tc1 through Tc2 of a write. Both are inactive for the whole of a read.
- R8: A refresh request seen in idle wins over a pending access and produces three states with the refresh indicator low and write enable high. Both column strobes (on the latched pin pair) are low in the second and third states, all row strobes are low in the third, and the refresh done pulse is high in the third. The refresh indicator is high at every other time.
- R9: A non-DRAM request accepted on the cycle right after Tc2 of an access with pin select 1 gets one idle state (all strobes inactive, ready low), and the go pulse comes one cycle later. Otherwise the go pulse is high in the cycle right after acceptance.
- R10: Ready is high only in idle, and the access-done output is high only in Tc2.
- R11: During and right after reset, all strobes and write enable are high, the refresh indicator is high, the address and output enable are zero, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_dram | input | 1 | 1: DRAM area access, 0: other external area |
| req_area | input | 2 | DRAM area index (0..3 for areas 2..5) |
| req_write | input | 1 | 1: write, 0: read |
| req_ub | input | 1 | Upper byte lane enable |
| req_lb | input | 1 | Lower byte lane enable |
| req_addr | input | 23 | Word address, row in bits 22..10, column in 9..0 |
| req_csel | input | 1 | Column strobe pins: 0 port pair, 1 write-strobe pair |
| wait_en | input | 4 | Per-area wait-enable bits |
| wait_req | input | 1 | Wait request |
| rfsh_req | input | 1 | Refresh request |
| req_ready | output | 1 | Idle, request can be taken |
| ras_n | output | 4 | Row strobes, one per area |
| pcas_hi_n | output | 1 | Upper column strobe on port pin |
| pcas_lo_n | output | 1 | Lower column strobe on port pin |
| wstb_hi_n | output | 1 | Upper column strobe on high write-strobe pin |
| wstb_lo_n | output | 1 | Lower column strobe on low write-strobe pin |
| we_n | output | 1 | Write enable |
| rfsh_n | output | 1 | Refresh indicator |
| ma | output | 13 | Multiplexed row/column address |
| data_oe | output | 1 | Data bus output enable |
| acc_done | output | 1 | Last state of a DRAM access |
| rf_done | output | 1 | Last state of a refresh |
| ext_go | output | 1 | Hand-off pulse for a non-DRAM access |

## Verification
The assertions watch properties that must hold on every cycle. At most one row strobe is low outside refresh, and the two column-strobe pin pairs are never active together. A column strobe never appears without a row strobe or refresh, and write enable stays away from refresh. On the sequencing side they check that a wait state is only entered after a sampled wait request under an enabled area, and that it is only left after the request drops. They also check that refresh starts from idle and that no hand-off pulse directly follows a write-strobe-pin access. The exact cycle count of each access and the row/column values on the address bus cannot be shown by those properties alone. Neither can the routing of lanes to pins per vector, refresh priority over a pending access, or the presence or absence of the idle state. These are shown by the bench scenarios.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TP,
    S_TR,
    S_TC1,
    S_TW,
    S_TC2,
    S_TI,
    S_TX,
    S_RFP,
    S_RFC,
    S_RFR
  } seq_state_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int MA_W   = 13,
  parameter int COL_W  = 10,
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA),
  localparam int ADDR_W = MA_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dram,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_ub,
  input  logic              req_lb,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_csel,
  input  logic [N_AREA-1:0] wait_en,
  input  logic              wait_req,
  input  logic              rfsh_req,
  output seq_state_t        state,
  output logic [AREA_W-1:0] lat_area,
  output logic              lat_write,
  output logic              lat_ub,
  output logic              lat_lb,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_csel
);

  seq_state_t nxt;
  logic       lat_wen;
  logic       need_idle;

  // named acceptance events
  logic in_idle, rf_take, acc_take, dram_take;
  assign in_idle   = (state == S_IDLE);
  assign rf_take   = in_idle && rfsh_req;
  assign acc_take  = in_idle && !rfsh_req && req_valid;
  assign dram_take = acc_take && req_dram;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (rf_take)       nxt = S_RFP;
        else if (acc_take) nxt = req_dram ? S_TP : (need_idle ? S_TI : S_TX);
      end
      S_TP:  nxt = S_TR;
      S_TR:  nxt = S_TC1;
      S_TC1: nxt = (lat_wen && wait_req) ? S_TW : S_TC2;
      S_TW:  nxt = wait_req ? S_TW : S_TC2;
      S_TC2: nxt = S_IDLE;
      S_TI:  nxt = S_TX;
      S_TX:  nxt = S_IDLE;
      S_RFP: nxt = S_RFC;
      S_RFC: nxt = S_RFR;
      S_RFR: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      need_idle <= 1'b0;
      lat_area  <= '0;
      lat_write <= 1'b0;
      lat_ub    <= 1'b0;
      lat_lb    <= 1'b0;
      lat_addr  <= '0;
      lat_csel  <= 1'b0;
      lat_wen   <= 1'b0;
    end else begin
      state     <= nxt;
      need_idle <= (state == S_TC2) && lat_csel;
      if (dram_take) begin
        lat_area  <= req_area;
        lat_write <= req_write;
        lat_ub    <= req_ub;
        lat_lb    <= req_lb;
        lat_addr  <= req_addr;
        lat_wen   <= wait_en[req_area];
      end
      if (dram_take || rf_take) lat_csel <= req_csel;
    end
  end

  // R4: a wait state is entered only after a sampled wait request
  assert_wait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TW) |-> $past(wait_req));

  // R4: the wait state is left only once the request was sampled low
  assert_wait_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_TW && state == S_TC2) |-> !$past(wait_req));

  // R5: no wait state under a disabled area
  assert_no_wait_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TW) |-> lat_wen);

  // R9: no hand-off directly after a write-strobe-pin access
  assert_idle_inserted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX) |-> !($past(state, 2) == S_TC2 && $past(lat_csel, 2)));

  // R1: row state always follows precharge
  assert_tp_then_tr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TP) |=> (state == S_TR));

endmodule

// File: rtl/dram_seq_pins.sv
module dram_seq_pins
  import dram_seq_pkg::*;
#(
  parameter int MA_W   = 13,
  parameter int COL_W  = 10,
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA),
  localparam int ADDR_W = MA_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic [AREA_W-1:0] lat_area,
  input  logic              lat_write,
  input  logic              lat_ub,
  input  logic              lat_lb,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              lat_csel,
  output logic              req_ready,
  output logic [N_AREA-1:0] ras_n,
  output logic              pcas_hi_n,
  output logic              pcas_lo_n,
  output logic              wstb_hi_n,
  output logic              wstb_lo_n,
  output logic              we_n,
  output logic              rfsh_n,
  output logic [MA_W-1:0]   ma,
  output logic              data_oe,
  output logic              acc_done,
  output logic              rf_done,
  output logic              ext_go
);

  function automatic logic [MA_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: MA_W];
  endfunction

  function automatic logic [MA_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return MA_W'(a[COL_W-1:0]);
  endfunction

  function automatic logic [N_AREA-1:0] area_dec(input logic [AREA_W-1:0] idx);
    return N_AREA'(1) << idx;
  endfunction

  // named phase wires
  logic ph_row, ph_col, ph_rf, cas_hi, cas_lo;
  assign ph_row = (state == S_TP) || (state == S_TR);
  assign ph_col = (state == S_TC1) || (state == S_TW) || (state == S_TC2);
  assign ph_rf  = (state == S_RFP) || (state == S_RFC) || (state == S_RFR);

  assign cas_hi = ((state == S_TC2) && lat_ub) || (state == S_RFC) || (state == S_RFR);
  assign cas_lo = ((state == S_TC2) && lat_lb) || (state == S_RFC) || (state == S_RFR);

  always_comb begin
    if (state == S_TR || ph_col) ras_n = ~area_dec(lat_area);
    else if (state == S_RFR)     ras_n = '0;
    else                         ras_n = '1;
  end

  assign pcas_hi_n = !(cas_hi && !lat_csel);
  assign pcas_lo_n = !(cas_lo && !lat_csel);
  assign wstb_hi_n = !(cas_hi && lat_csel);
  assign wstb_lo_n = !(cas_lo && lat_csel);

  assign we_n    = !(lat_write && ph_col);
  assign data_oe = lat_write && ph_col;
  assign rfsh_n  = !ph_rf;
  assign ma      = ph_row ? row_of(lat_addr) : (ph_col ? col_of(lat_addr) : '0);

  assign req_ready = (state == S_IDLE);
  assign acc_done  = (state == S_TC2);
  assign rf_done   = (state == S_RFR);
  assign ext_go    = (state == S_TX);

  // R2: outside refresh at most one row strobe is active
  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_n |-> ($countones(~ras_n) <= 1));

  // R6: the two column strobe pairs never act together
  assert_pair_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((!pcas_hi_n || !pcas_lo_n) && (!wstb_hi_n || !wstb_lo_n)));

  // R6: a column strobe needs an active row strobe or a refresh
  assert_cas_under_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcas_hi_n || !pcas_lo_n || !wstb_hi_n || !wstb_lo_n) |-> (!rfsh_n || ras_n != '1));

  // R7: write enable only with driven data and never during refresh
  assert_we_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (rfsh_n && data_oe));

  // R8: refresh begins only from the idle state
  assert_rfsh_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n) |-> $past(req_ready));

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int MA_W   = 13,
  parameter int COL_W  = 10,
  parameter int N_AREA = 4,
  localparam int AREA_W = $clog2(N_AREA),
  localparam int ADDR_W = MA_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_dram,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_ub,
  input  logic              req_lb,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_csel,
  input  logic [N_AREA-1:0] wait_en,
  input  logic              wait_req,
  input  logic              rfsh_req,
  output logic              req_ready,
  output logic [N_AREA-1:0] ras_n,
  output logic              pcas_hi_n,
  output logic              pcas_lo_n,
  output logic              wstb_hi_n,
  output logic              wstb_lo_n,
  output logic              we_n,
  output logic              rfsh_n,
  output logic [MA_W-1:0]   ma,
  output logic              data_oe,
  output logic              acc_done,
  output logic              rf_done,
  output logic              ext_go
);

  seq_state_t        state;
  logic [AREA_W-1:0] lat_area;
  logic              lat_write, lat_ub, lat_lb, lat_csel;
  logic [ADDR_W-1:0] lat_addr;

  dram_seq_ctrl #(.MA_W(MA_W), .COL_W(COL_W), .N_AREA(N_AREA)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_dram(req_dram), .req_area(req_area),
    .req_write(req_write), .req_ub(req_ub), .req_lb(req_lb),
    .req_addr(req_addr), .req_csel(req_csel), .wait_en(wait_en),
    .wait_req(wait_req), .rfsh_req(rfsh_req),
    .state(state), .lat_area(lat_area), .lat_write(lat_write),
    .lat_ub(lat_ub), .lat_lb(lat_lb), .lat_addr(lat_addr), .lat_csel(lat_csel)
  );

  dram_seq_pins #(.MA_W(MA_W), .COL_W(COL_W), .N_AREA(N_AREA)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .state(state), .lat_area(lat_area), .lat_write(lat_write),
    .lat_ub(lat_ub), .lat_lb(lat_lb), .lat_addr(lat_addr), .lat_csel(lat_csel),
    .req_ready(req_ready), .ras_n(ras_n),
    .pcas_hi_n(pcas_hi_n), .pcas_lo_n(pcas_lo_n),
    .wstb_hi_n(wstb_hi_n), .wstb_lo_n(wstb_lo_n),
    .we_n(we_n), .rfsh_n(rfsh_n), .ma(ma), .data_oe(data_oe),
    .acc_done(acc_done), .rf_done(rf_done), .ext_go(ext_go)
  );

endmodule

// File: tb/dram_cycle_seq_test.sv
`timescale 1ns/1ps
module dram_cycle_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_dram = 1'b0, req_write = 1'b0;
  logic        req_ub = 1'b0, req_lb = 1'b0, req_csel = 1'b0;
  logic [1:0]  req_area = '0;
  logic [22:0] req_addr = '0;
  logic [3:0]  wait_en = '0;
  logic        wait_req = 1'b0, rfsh_req = 1'b0;

  logic        req_ready, pcas_hi_n, pcas_lo_n, wstb_hi_n, wstb_lo_n;
  logic        we_n, rfsh_n, data_oe, acc_done, rf_done, ext_go;
  logic [3:0]  ras_n;
  logic [12:0] ma;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dram_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dram(req_dram),
    .req_area(req_area), .req_write(req_write), .req_ub(req_ub), .req_lb(req_lb),
    .req_addr(req_addr), .req_csel(req_csel), .wait_en(wait_en),
    .wait_req(wait_req), .rfsh_req(rfsh_req), .req_ready(req_ready),
    .ras_n(ras_n), .pcas_hi_n(pcas_hi_n), .pcas_lo_n(pcas_lo_n),
    .wstb_hi_n(wstb_hi_n), .wstb_lo_n(wstb_lo_n), .we_n(we_n), .rfsh_n(rfsh_n),
    .ma(ma), .data_oe(data_oe), .acc_done(acc_done), .rf_done(rf_done),
    .ext_go(ext_go)
  );

  // observed bundle: ras4 pch pcl wsh wsl we oe rfsh ma13 rdy done rfd go
  logic [27:0] seen;
  assign seen = {ras_n, pcas_hi_n, pcas_lo_n, wstb_hi_n, wstb_lo_n, we_n, data_oe,
                 rfsh_n, ma, req_ready, acc_done, rf_done, ext_go};

  typedef struct packed {
    logic [1:0]  area;
    logic        write;
    logic        ub;
    logic        lb;
    logic        csel;
    logic        wen;
    logic [2:0]  nw;
    logic [22:0] addr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 23'h012345},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 23'h07ABCD},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 23'h000FFF},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 23'h05A5A5},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 23'h7FFFFF},
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 23'h000400},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 23'h000000},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 23'h02AAAA}
  };

  // phases: 0 idle, 1 precharge, 2 row, 3 col1, 4 wait, 5 col2
  function automatic logic [27:0] expect_acc(input int p, input vec_t v);
    logic [3:0]  r;
    logic        hi, lo, wr, oe;
    logic [12:0] a;
    r  = (p >= 2 && p <= 5) ? ~(4'b0001 << v.area) : 4'hF;
    hi = (p == 5) && v.ub;
    lo = (p == 5) && v.lb;
    wr = v.write && p >= 3 && p <= 5;
    oe = wr;
    if (p == 1 || p == 2)      a = v.addr[22:10];
    else if (p >= 3 && p <= 5) a = {3'b000, v.addr[9:0]};
    else                       a = '0;
    return {r, !(hi && !v.csel), !(lo && !v.csel), !(hi && v.csel), !(lo && v.csel),
            !wr, oe, 1'b1, a, p == 0, p == 5, 1'b0, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [27:0] exp);
    checks++;
    if (seen !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, seen, exp, $time);
    end
  endtask

  task automatic run_access(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_dram = 1'b1; req_area = v.area; req_write = v.write;
    req_ub = v.ub; req_lb = v.lb; req_addr = v.addr; req_csel = v.csel;
    wait_en = v.wen ? (4'b0001 << v.area) : ~(4'b0001 << v.area);
    @(negedge clk); req_valid = 1'b0; check("R1 R3 Tp", expect_acc(1, v));
    @(negedge clk); check("R1 R2 R3 Tr", expect_acc(2, v));
    @(negedge clk); check("R1 R3 R7 Tc1", expect_acc(3, v));
    wait_req = (v.nw > 0);
    if (v.wen) begin
      for (int i = 0; i < int'(v.nw); i++) begin
        @(negedge clk);
        wait_req = (i + 1 < int'(v.nw));
        check("R4 R2 wait", expect_acc(4, v));
      end
    end
    @(negedge clk); wait_req = 1'b0;
    check(v.wen ? "R4 R6 R10 Tc2" : "R5 R6 R10 Tc2", expect_acc(5, v));
    @(negedge clk); check("R1 R10 idle", expect_acc(0, v));
  endtask

  task automatic ext_req();
    req_valid = 1'b1; req_dram = 1'b0;
    @(negedge clk); req_valid = 1'b0;
  endtask

  localparam logic [27:0] IDLE_EXP = {4'hF, 4'hF, 1'b1, 1'b0, 1'b1, 13'd0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [27:0] TI_EXP   = {4'hF, 4'hF, 1'b1, 1'b0, 1'b1, 13'd0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [27:0] TX_EXP   = {4'hF, 4'hF, 1'b1, 1'b0, 1'b1, 13'd0, 1'b0, 1'b0, 1'b0, 1'b1};

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog R1: got hang expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    check("R11 in reset", IDLE_EXP);
    rst_n = 1'b1;
    @(negedge clk); check("R11 after reset", IDLE_EXP);

    for (int n = 0; n < NV; n++) run_access(VEC[n]);

    // R8: refresh wins over a simultaneous access, pins on write-strobe pair
    @(negedge clk);
    rfsh_req = 1'b1; req_csel = 1'b1;
    d = '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 23'h123456};
    req_valid = 1'b1; req_dram = 1'b1; req_area = d.area; req_write = d.write;
    req_ub = d.ub; req_lb = d.lb; req_addr = d.addr;
    @(negedge clk); rfsh_req = 1'b0; req_csel = 1'b0;
    check("R8 refresh state 1", {4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 13'd0, 4'b0000});
    @(negedge clk);
    check("R8 refresh state 2", {4'hF, 4'b1100, 1'b1, 1'b0, 1'b0, 13'd0, 4'b0000});
    @(negedge clk);
    check("R8 refresh state 3", {4'h0, 4'b1100, 1'b1, 1'b0, 1'b0, 13'd0, 4'b0010});
    @(negedge clk);
    check("R8 R10 idle before pending access", IDLE_EXP);
    @(negedge clk); req_valid = 1'b0;
    check("R8 R1 pending access starts", expect_acc(1, d));
    @(negedge clk); check("R8 R2 pending row", expect_acc(2, d));
    @(negedge clk); check("R8 R7 pending col1", expect_acc(3, d));
    @(negedge clk); check("R8 R6 pending col2", expect_acc(5, d));
    @(negedge clk); check("R8 idle", expect_acc(0, d));

    // R9: write-strobe pins then non-DRAM right away -> idle state inserted
    run_access(VEC[2]);
    ext_req();
    check("R9 idle state inserted", TI_EXP);
    @(negedge clk); check("R9 hand-off after idle state", TX_EXP);
    @(negedge clk); check("R9 back to idle", IDLE_EXP);

    // R9: port pins then non-DRAM right away -> no idle state
    run_access(VEC[0]);
    ext_req();
    check("R9 hand-off without idle state", TX_EXP);
    @(negedge clk); check("R9 idle", IDLE_EXP);

    // R9: write-strobe pins, a gap cycle, then non-DRAM -> no idle state
    run_access(VEC[7]);
    @(negedge clk); check("R9 gap cycle", IDLE_EXP);
    ext_req();
    check("R9 hand-off after gap", TX_EXP);

    // R11: reset mid-access returns to the quiet state
    run_access(VEC[1]);
    @(negedge clk);
    req_valid = 1'b1; req_dram = 1'b1; req_write = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    #1 check("R11 reset during access", IDLE_EXP);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R11 after second reset", IDLE_EXP);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule